// File: doc/BRIEF.md
# Two-Output Interrupt Router

This block gathers level-sensitive request lines from on-chip peripherals and presents them to a processor as two interrupt outputs. Each implemented source line has a mask bit and a steering bit. The mask decides whether the line can interrupt at all. The steering bit decides which of the two outputs the line drives. A master enable gates both outputs at once.

Software sees a small word-addressed register port. Mask bits never change through a plain write. They are set through one address and cleared through another, and a 1 in a data bit selects that mask bit, so drivers need no read-modify-write. The master enable sits in the top bit of both of those addresses. Two read-only registers show, for each output, the source lines that are pending, unmasked and steered to it. A third read-only register shows the request inputs with no masking applied. Each processor output is the OR of its status register and leaves through one flop.

Top module: `intr_route_ctrl`

## Requirements
- R1: After reset, all mask bits, the master enable and all steering bits are 0. Every register reads 0 and both outputs are low.
- R2: The register at offset 0x30 reads the request inputs ANDed with the implemented-line mask 0x000617FF, which covers bits 0 to 10, 12, 17 and 18. Bits outside that mask read 0 in every register.
- R3: A write to offset 0x34 sets each implemented mask bit whose data bit is 1, and sets the master enable when data bit 31 is 1. Data bits that are 0 leave their state unchanged.
- R4: A write to offset 0x38 clears each implemented mask bit whose data bit is 1, and clears the master enable when data bit 31 is 1. Data bits that are 0 leave their state unchanged.
- R5: Reads of 0x34 and 0x38 both return the current mask bits, with the master enable in bit 31.
- R6: Offset 0x20 holds the steering bits and stores only the implemented lines. A write replaces their value, and a read returns it.
- R7: The status register at 0x00 (output 0) reads raw AND mask AND NOT steering. The status register at 0x04 (output 1) reads raw AND mask AND steering.
- R8: While the master enable is 0, both status registers read 0 and both outputs fall low.
- R9: Output k goes high on the first rising clock edge after status register k becomes non-zero, and it goes low on the first rising edge after status register k becomes zero.
- R10: Writes to 0x00, 0x04, 0x30 and to unmapped offsets change no register state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | 32 | Level request lines from peripherals |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| cpu_irq0 | output | 1 | Registered interrupt output 0 |
| cpu_irq1 | output | 1 | Registered interrupt output 1 |

## Verification
The routing function is exercised with a walking one across all 32 request bits. It is then exercised with a pseudo-random request sequence under four steering patterns (all 0, all 1, alternating, and the inverse) and under partial masks. The walking one shows whether each line lands in its own bit and whether unimplemented lines are dropped. Complementary steering patterns show whether a line is sent to the wrong output or to both outputs. Re-running the sequences with the master enable off shows whether gating acts on both outputs. Sampling the outputs just before and just after the edge that follows a request change pins down the single flop of latency.

// File: rtl/intr_route_pkg.sv
package intr_route_pkg;

    localparam int unsigned DATA_W  = 32;
    localparam int unsigned ADDR_W  = 8;
    localparam int unsigned NUM_OUT = 2;
    localparam int unsigned GLB_BIT = DATA_W - 1;

    localparam logic [ADDR_W-1:0] OFS_STAT0 = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT1 = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_STEER = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_RAW   = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_MSET  = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_MCLR  = 8'h38;

    typedef struct packed {
        logic              glb;
        logic [DATA_W-1:0] msk;
        logic [DATA_W-1:0] steer;
    } ctl_state_t;

    typedef struct packed {
        logic [NUM_OUT-1:0] irq;
        logic               seen;
    } out_state_t;

endpackage

// File: rtl/intr_route_ctl.sv
module intr_route_ctl
    import intr_route_pkg::*;
#(
    parameter logic [DATA_W-1:0] IMPL_MASK = 32'h0006_17FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              glb_en,
    output logic [DATA_W-1:0] msk_bits,
    output logic [DATA_W-1:0] steer_bits
);

    ctl_state_t st_d, st_q;
    logic [DATA_W-1:0] sel_bits;

    always_comb begin
        st_d     = st_q;
        sel_bits = wr_data & IMPL_MASK;
        if (wr_en) begin
            unique case (wr_addr)
                OFS_MSET: begin
                    st_d.msk = st_q.msk | sel_bits;
                    if (wr_data[GLB_BIT]) st_d.glb = 1'b1;
                end
                OFS_MCLR: begin
                    st_d.msk = st_q.msk & ~sel_bits;
                    if (wr_data[GLB_BIT]) st_d.glb = 1'b0;
                end
                OFS_STEER: begin
                    st_d.steer = sel_bits;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign glb_en     = st_q.glb;
    assign msk_bits   = st_q.msk;
    assign steer_bits = st_q.steer;

    // R3: a set write leaves every selected line enabled
    p_set_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFS_MSET) |=>
        ((msk_bits & ($past(wr_data) & IMPL_MASK)) == ($past(wr_data) & IMPL_MASK)));

    // R4: a clear write leaves every selected line disabled
    p_clr_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFS_MCLR) |=>
        ((msk_bits & $past(wr_data) & IMPL_MASK) == '0));

    // R10: writes to read-only or unmapped offsets leave the state alone
    p_ro_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != OFS_MSET && wr_addr != OFS_MCLR && wr_addr != OFS_STEER) |=>
        ($stable(msk_bits) && $stable(steer_bits) && $stable(glb_en)));

    // R2: no state outside the implemented lines
    p_impl_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((msk_bits | steer_bits) & ~IMPL_MASK) == '0);

endmodule

// File: rtl/intr_route_steer.sv
module intr_route_steer
    import intr_route_pkg::*;
#(
    parameter logic [DATA_W-1:0] IMPL_MASK = 32'h0006_17FF
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [DATA_W-1:0]               req,
    input  logic                            glb_en,
    input  logic [DATA_W-1:0]               msk_bits,
    input  logic [DATA_W-1:0]               steer_bits,
    output logic [DATA_W-1:0]               raw,
    output logic [NUM_OUT-1:0][DATA_W-1:0]  stat
);

    logic [DATA_W-1:0] live;

    always_comb begin
        raw  = req & IMPL_MASK;
        live = raw & msk_bits;
    end

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
        logic [DATA_W-1:0] pick;
        if (k == 0) begin : g_lo
            assign pick = ~steer_bits;
        end else begin : g_hi
            assign pick = steer_bits;
        end
        always_comb begin
            stat[k] = glb_en ? (live & pick) : '0;
        end
    end

    // R7: no line is ever reported on both outputs
    p_disjoint_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[0] & stat[1]) == '0);

    // R8: master enable off gates every status bit
    p_glb_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |-> (stat[0] == '0 && stat[1] == '0));

    // R7: together the outputs cover exactly the enabled pending lines
    p_cover_r7: assert property (@(posedge clk) disable iff (!rst_n)
        glb_en |-> ((stat[0] | stat[1]) == (req & msk_bits & IMPL_MASK)));

endmodule

// File: rtl/intr_route_rdmux.sv
module intr_route_rdmux
    import intr_route_pkg::*;
(
    input  logic [ADDR_W-1:0]              rd_addr,
    input  logic [NUM_OUT-1:0][DATA_W-1:0] stat,
    input  logic [DATA_W-1:0]              raw,
    input  logic                           glb_en,
    input  logic [DATA_W-1:0]              msk_bits,
    input  logic [DATA_W-1:0]              steer_bits,
    output logic [DATA_W-1:0]              rd_data
);

    logic [DATA_W-1:0] msk_view;

    always_comb begin
        msk_view          = msk_bits;
        msk_view[GLB_BIT] = glb_en;
        unique case (rd_addr)
            OFS_STAT0: rd_data = stat[0];
            OFS_STAT1: rd_data = stat[1];
            OFS_STEER: rd_data = steer_bits;
            OFS_RAW:   rd_data = raw;
            OFS_MSET,
            OFS_MCLR:  rd_data = msk_view;
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/intr_route_ctrl.sv
module intr_route_ctrl
    import intr_route_pkg::*;
#(
    parameter logic [31:0] IMPL_MASK = 32'h0006_17FF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] src_req,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        cpu_irq0,
    output logic        cpu_irq1
);

    localparam logic [DATA_W-1:0] LINE_MASK = IMPL_MASK & ~(32'h1 << GLB_BIT);

    logic                           glb_en;
    logic [DATA_W-1:0]              msk_bits;
    logic [DATA_W-1:0]              steer_bits;
    logic [DATA_W-1:0]              raw;
    logic [NUM_OUT-1:0][DATA_W-1:0] stat;
    out_state_t                     out_d, out_q;

    intr_route_ctl #(.IMPL_MASK(LINE_MASK)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_we),
        .wr_addr    (reg_addr),
        .wr_data    (reg_wdata),
        .glb_en     (glb_en),
        .msk_bits   (msk_bits),
        .steer_bits (steer_bits)
    );

    intr_route_steer #(.IMPL_MASK(LINE_MASK)) u_steer (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (src_req),
        .glb_en     (glb_en),
        .msk_bits   (msk_bits),
        .steer_bits (steer_bits),
        .raw        (raw),
        .stat       (stat)
    );

    intr_route_rdmux u_rdmux (
        .rd_addr    (reg_addr),
        .stat       (stat),
        .raw        (raw),
        .glb_en     (glb_en),
        .msk_bits   (msk_bits),
        .steer_bits (steer_bits),
        .rd_data    (reg_rdata)
    );

    always_comb begin
        out_d      = out_q;
        out_d.seen = 1'b1;
        for (int k = 0; k < NUM_OUT; k++) begin
            out_d.irq[k] = |stat[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign cpu_irq0 = out_q.irq[0];
    assign cpu_irq1 = out_q.irq[1];

    // R9: each output shows its status one edge later
    p_irq_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.seen |-> (cpu_irq0 == $past(|stat[0]) && cpu_irq1 == $past(|stat[1])));

    // R2: reads never expose unimplemented lines
    p_rd_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != OFS_MSET && reg_addr != OFS_MCLR) |-> ((reg_rdata & ~LINE_MASK) == '0));

    // R8: master enable off keeps both outputs low after one edge
    p_out_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.seen && !$past(glb_en)) |-> (!cpu_irq0 && !cpu_irq1));

endmodule

// File: tb/intr_route_ctrl_test.sv
module intr_route_ctrl_test;

    localparam logic [31:0] MASK = 32'h0006_17FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_req = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cpu_irq0, cpu_irq1;

    int n_vec = 0;
    int n_bad = 0;

    logic        m_glb = 1'b0;
    logic [31:0] m_msk = '0;
    logic [31:0] m_typ = '0;

    intr_route_ctrl uut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cpu_irq0(cpu_irq0), .cpu_irq1(cpu_irq1)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] exp_stat(input int k, input logic [31:0] r);
        logic [31:0] sel;
        sel = (k == 0) ? ~m_typ : m_typ;
        return m_glb ? (r & MASK & m_msk & sel) : 32'h0;
    endfunction

    task automatic chk_regs(input string tag);
        logic [31:0] v;
        rd(8'h34, v); chk({tag, " R5 set-view"}, v, {m_glb, m_msk[30:0]});
        rd(8'h38, v); chk({tag, " R5 clr-view"}, v, {m_glb, m_msk[30:0]});
        rd(8'h20, v); chk({tag, " R6 steer"}, v, m_typ);
    endtask

    // apply a request pattern; check reads and the one-edge output lag (R7, R9)
    task automatic apply(input string tag, input logic [31:0] r);
        logic [31:0] v;
        logic p0, p1;
        @(negedge clk);
        p0 = cpu_irq0; p1 = cpu_irq1;
        src_req = r;
        rd(8'h30, v); chk({tag, " R2 raw"}, v, r & MASK);
        rd(8'h00, v); chk({tag, " R7 stat0"}, v, exp_stat(0, r));
        rd(8'h04, v); chk({tag, " R7 stat1"}, v, exp_stat(1, r));
        chk({tag, " R9 irq0 hold"}, {31'b0, cpu_irq0}, {31'b0, p0});
        chk({tag, " R9 irq1 hold"}, {31'b0, cpu_irq1}, {31'b0, p1});
        @(posedge clk); #1;
        chk({tag, " R9 irq0"}, {31'b0, cpu_irq0}, {31'b0, |exp_stat(0, r)});
        chk({tag, " R9 irq1"}, {31'b0, cpu_irq1}, {31'b0, |exp_stat(1, r)});
    endtask

    initial begin : wdog
        #1_000_000;
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        logic [31:0] lfsr;
        logic [31:0] typs [4];
        typs[0] = 32'h0; typs[1] = 32'hFFFF_FFFF; typs[2] = 32'h5555_5555; typs[3] = 32'hAAAA_AAAA;

        src_req = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        rd(8'h00, v); chk("R1 stat0", v, 0);
        rd(8'h04, v); chk("R1 stat1", v, 0);
        chk_regs("R1");
        @(negedge clk);
        chk("R1 irq", {30'b0, cpu_irq1, cpu_irq0}, 0);

        // R2 walking one with nothing enabled
        for (int i = 0; i < 32; i++) apply("R2 walk", 32'h1 << i);

        // R10 writes to read-only and unmapped offsets
        wr(8'h00, 32'hFFFF_FFFF); wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h30, 32'hFFFF_FFFF); wr(8'h3C, 32'hFFFF_FFFF); wr(8'h24, 32'hFFFF_FFFF);
        chk_regs("R10");

        // R3 set with partial patterns, zero data has no effect
        wr(8'h34, 32'h0000_00F0); m_msk = 32'h0000_00F0; chk_regs("R3 a");
        wr(8'h34, 32'h0000_0000); chk_regs("R3 zero");
        wr(8'h34, 32'h0006_1003); m_msk |= 32'h0006_1003; chk_regs("R3 b");
        wr(8'h34, 32'h8000_0000); m_glb = 1'b1; chk_regs("R3 glb");
        wr(8'h34, 32'h7FFF_FFFF); m_msk = MASK; chk_regs("R3 all");

        // R6 steering stores only implemented lines
        wr(8'h20, 32'hFFFF_FFFF); m_typ = MASK; chk_regs("R6 all");

        // R7, R8, R9 sweep: steering patterns x master enable x request sequences
        for (int g = 1; g >= 0; g--) begin
            if (g == 0) begin
                wr(8'h38, 32'h8000_0000); m_glb = 1'b0; chk_regs("R4 glb");
            end
            for (int t = 0; t < 4; t++) begin
                wr(8'h20, typs[t]); m_typ = typs[t] & MASK; chk_regs("R6 sweep");
                lfsr = 32'hACE1_1357 ^ (t * 32'h0101_0101);
                for (int n = 0; n < 40; n++) begin
                    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                    apply(g ? "R7 on" : "R8 off", lfsr);
                end
                for (int i = 0; i < 32; i++) apply(g ? "R7 walk" : "R8 walk", 32'h1 << i);
                apply(g ? "R7 all" : "R8 all", 32'hFFFF_FFFF);
            end
        end

        // R4 clear with partial patterns, zero data has no effect
        wr(8'h34, 32'h8000_0000); m_glb = 1'b1;
        wr(8'h38, 32'h0000_0000); chk_regs("R4 zero");
        wr(8'h38, 32'h0002_0505); m_msk &= ~32'h0002_0505; chk_regs("R4 a");
        wr(8'h20, 32'h0000_0F0F); m_typ = 32'h0000_0F0F & MASK;
        for (int i = 0; i < 32; i++) apply("R4 walk", 32'h1 << i);
        apply("R4 all", 32'hFFFF_FFFF);
        apply("R9 drop", 32'h0);
        wr(8'h38, 32'h7FFF_FFFF); m_msk = 0; chk_regs("R4 all");
        apply("R4 none", 32'hFFFF_FFFF);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule